// File: doc/BRIEF.md
# Soft-Start and Protection Sequencer

This block supervises start-up and fault handling for one switching-regulator channel. Analog comparators outside the block deliver their verdicts as flags, sampled once per switching cycle on a strobe. The block turns those flags, together with the enable level and the supply-ok flag, into four things: a digital soft-start reference code, the PWM enable, the enable for the low-side synchronous rectifier, and a power-good indication. When protection trips, it raises a latched-fault output and a request to discharge the enable line.

The reference code climbs by one step on each switching cycle. The time it takes therefore scales with the switching frequency. The code passes the regulation point `REG_CODE` and stops at `END_CODE`, which marks the end of soft-start. Over-current protection is armed for the whole ramp. Over- and under-voltage protection and power-good wait until the ramp is finished. Each protection has its own consecutive-cycle filter. A shorted high-side switch and over-temperature bypass these filters. After a fault the channel stays off until the enable line goes low and then high again, or until the supply-ok flag drops.

Top module: `startFaultSupervisor`

## Requirements
- R1: After reset, and while `uvloOk` is low, `ssCode` is 0 and every other output is low.
- R2: The block leaves idle, with `pwmEn` high one clock later, only when all four of these hold together: `uvloOk` is high, `enLevel` is high, `fbShort` is low and `otHot` is low. While `fbShort` is high the block stays idle.
- R3: During the ramp, `ssCode` rises by exactly 1 on each clock edge that samples `cycleStb` high, starting from 0. Once it reaches `END_CODE` it holds there and the block enters run on the next clock. `pwmEn` is high during both ramp and run.
- R4: `syncRectEn` is low while the ramp code is below `SYNC_CODE` = floor(`REG_CODE`*95/100). It is high from that code onward and for the whole of run.
- R5: Before run, `uvFlag`, `ovFlag` and `pgOutFlag` have no effect, so neither a fault nor power-good results. `ocFlag` is acted on throughout the ramp.
- R6: `uvFlag` sampled high on `UV_LEN` consecutive strobes during run sets `faultLatched` one clock after the last of them.
- R7: `ovFlag` sampled high on `OV_LEN` consecutive strobes during run sets `faultLatched` one clock after the last of them.
- R8: `ocFlag` sampled high on `OC_LEN` consecutive strobes during ramp or run sets `faultLatched` one clock after the last of them. A single strobe with the flag low restarts that count. The same restart applies to every filter.
- R9: `hsShort` high during ramp or run sets `faultLatched` on the next clock, with no strobe needed.
- R10: `otHot` high during ramp or run sets `faultLatched` on the next clock. While `otHot` is high, no new start takes place.
- R11: `powerGood` is high only in run. It drops right after the strobe that completes `PG_LEN` consecutive samples of `pgOutFlag` high. It comes back after one strobe with `pgOutFlag` low.
- R12: In fault, `faultLatched` and `enDischarge` are high and `pwmEn` and `syncRectEn` are low. `ssCode` returns to 0 one clock later. Fault is held while `enLevel` stays high. `enLevel` low returns the block to idle, and `enLevel` high afterwards starts a fresh ramp from 0.
- R13: `enLevel` low or `uvloOk` low drives the block to idle on the next clock from any state, which clears `faultLatched`. `ssCode` reaches 0 one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleStb | input | 1 | One-clock strobe per switching cycle |
| uvloOk | input | 1 | Supply above lockout threshold |
| enLevel | input | 1 | Enable line level |
| fbShort | input | 1 | Feedback input shorted |
| uvFlag | input | 1 | Feedback below under-voltage threshold |
| ovFlag | input | 1 | Feedback above over-voltage threshold |
| ocFlag | input | 1 | Cycle-by-cycle current limit hit |
| pgOutFlag | input | 1 | Feedback outside power-good window |
| hsShort | input | 1 | High-side switch shorted |
| otHot | input | 1 | Die over temperature (hysteresis applied upstream) |
| ssCode | output | CODE_W | Soft-start reference code |
| pwmEn | output | 1 | PWM switching enable |
| syncRectEn | output | 1 | Low-side synchronous rectifier enable |
| powerGood | output | 1 | Output in regulation window |
| faultLatched | output | 1 | Protection fault latched |
| enDischarge | output | 1 | Request to discharge the enable line |

## Verification
The bench builds the block with `CODE_W`=8, `REG_CODE`=32 and `END_CODE`=40, so `SYNC_CODE` is 30. The filter lengths stay at 16, 2, 16 and 2. With these values a complete ramp takes only 40 strobes. That is short enough to let a single run cover the full ramp, the rectifier threshold at codes 29 and 30, and an over-current trip that falls entirely inside the ramp. With the filter lengths left at their defaults, the 15-versus-16 and 1-versus-2 boundaries are exercised exactly as the protections specify.

// File: rtl/startFaultPkg.sv
package startFaultPkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RAMP  = 2'd1,
    S_RUN   = 2'd2,
    S_FAULT = 2'd3
  } supStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;     // hold code and filters at zero
    logic rampAdvance;  // step the soft-start code this clock
    logic ocArm;        // current-limit filter counts
    logic voltArm;      // voltage and window filters count
  } dpCtrlT;

  // status from datapath to control
  typedef struct packed {
    logic codeAtEnd;
    logic codeAtSync;
    logic uvHeld;
    logic ovHeld;
    logic ocHeld;
    logic pgLost;
  } dpStatT;

endpackage

// File: rtl/consecFilter.sv
module consecFilter #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic stb,
  input  logic cond,
  output logic held
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(LEN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (stb) begin
      if (!cond) begin
        cnt <= '0;
      end else if (cnt != FULL) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign held = (cnt == FULL);

  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= FULL);

  assert_held_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(held) |-> $past(stb && cond && !clr));

endmodule

// File: rtl/startFaultDatapath.sv
module startFaultDatapath
  import startFaultPkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int END_CODE  = 1000,
  parameter int SYNC_CODE = 760,
  parameter int UV_LEN    = 16,
  parameter int OV_LEN    = 2,
  parameter int OC_LEN    = 16,
  parameter int PG_LEN    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStb,
  input  logic              uvFlag,
  input  logic              ovFlag,
  input  logic              ocFlag,
  input  logic              pgOutFlag,
  input  dpCtrlT            ctl,
  output dpStatT            stat,
  output logic [CODE_W-1:0] ssCode
);
  localparam logic [CODE_W-1:0] CODE_END  = CODE_W'(END_CODE);
  localparam logic [CODE_W-1:0] CODE_SYNC = CODE_W'(SYNC_CODE);
  localparam int NFILT = 4;
  localparam int LENS [NFILT] = '{UV_LEN, OV_LEN, OC_LEN, PG_LEN};

  logic [NFILT-1:0] condVec;
  logic [NFILT-1:0] clrVec;
  logic [NFILT-1:0] heldVec;

  // soft-start code
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssCode <= '0;
    end else if (ctl.clearAll) begin
      ssCode <= '0;
    end else if (ctl.rampAdvance && (ssCode < CODE_END)) begin
      ssCode <= ssCode + 1'b1;
    end
  end

  // filter wiring: 0 uv, 1 ov, 2 oc, 3 power-good window
  assign condVec = {pgOutFlag, ocFlag, ovFlag, uvFlag};
  assign clrVec  = {!ctl.voltArm, !ctl.ocArm, !ctl.voltArm, !ctl.voltArm};

  for (genvar g = 0; g < NFILT; g++) begin : gFilt
    consecFilter #(.LEN(LENS[g])) uFilt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (clrVec[g]),
      .stb  (cycleStb),
      .cond (condVec[g]),
      .held (heldVec[g])
    );
  end

  always_comb begin
    stat.codeAtEnd  = (ssCode == CODE_END);
    stat.codeAtSync = (ssCode >= CODE_SYNC);
    stat.uvHeld     = heldVec[0];
    stat.ovHeld     = heldVec[1];
    stat.ocHeld     = heldVec[2];
    stat.pgLost     = heldVec[3];
  end

  assert_code_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rampAdvance && !ctl.clearAll && (ssCode < CODE_END)) |=>
      (ssCode == $past(ssCode) + 1'b1));

  assert_code_cap_R3: assert property (@(posedge clk) disable iff (!rstN)
    ssCode <= CODE_END);

endmodule

// File: rtl/startFaultCtrl.sv
module startFaultCtrl
  import startFaultPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cycleStb,
  input  logic   uvloOk,
  input  logic   enLevel,
  input  logic   fbShort,
  input  logic   hsShort,
  input  logic   otHot,
  input  dpStatT stat,
  output dpCtrlT ctl,
  output logic   pwmEn,
  output logic   syncRectEn,
  output logic   powerGood,
  output logic   faultLatched,
  output logic   enDischarge
);
  supStateT state, nxt;

  logic liveTrip, runTrip;
  assign liveTrip = hsShort || otHot || stat.ocHeld;
  assign runTrip  = liveTrip || stat.uvHeld || stat.ovHeld;

  always_comb begin
    nxt = state;
    if (!uvloOk) begin
      nxt = S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (enLevel && !fbShort && !otHot) nxt = S_RAMP;
        S_RAMP: begin
          if (!enLevel)            nxt = S_IDLE;
          else if (liveTrip)       nxt = S_FAULT;
          else if (stat.codeAtEnd) nxt = S_RUN;
        end
        S_RUN: begin
          if (!enLevel)     nxt = S_IDLE;
          else if (runTrip) nxt = S_FAULT;
        end
        S_FAULT: if (!enLevel) nxt = S_IDLE;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    ctl.clearAll    = (state == S_IDLE) || (state == S_FAULT);
    ctl.rampAdvance = (state == S_RAMP) && cycleStb;
    ctl.ocArm       = (state == S_RAMP) || (state == S_RUN);
    ctl.voltArm     = (state == S_RUN);
  end

  assign pwmEn        = (state == S_RAMP) || (state == S_RUN);
  assign syncRectEn   = ((state == S_RAMP) && stat.codeAtSync) || (state == S_RUN);
  assign powerGood    = (state == S_RUN) && !stat.pgLost;
  assign faultLatched = (state == S_FAULT);
  assign enDischarge  = (state == S_FAULT);

  assert_fault_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && enLevel && uvloOk) |=> faultLatched);

  assert_en_low_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!enLevel || !uvloOk) |=> (!pwmEn && !faultLatched));

  assert_uv_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat.uvHeld) |-> ($past(state) == S_RUN));

  assert_ov_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat.ovHeld) |-> ($past(state) == S_RUN));

  assert_pg_late_R11: assert property (@(posedge clk) disable iff (!rstN)
    powerGood |-> stat.codeAtEnd);

  assert_hs_short_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEn && hsShort && enLevel && uvloOk) |=> faultLatched);

endmodule

// File: rtl/startFaultSupervisor.sv
module startFaultSupervisor
  import startFaultPkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int REG_CODE = 800,
  parameter int END_CODE = 1000,
  parameter int UV_LEN   = 16,
  parameter int OV_LEN   = 2,
  parameter int OC_LEN   = 16,
  parameter int PG_LEN   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStb,
  input  logic              uvloOk,
  input  logic              enLevel,
  input  logic              fbShort,
  input  logic              uvFlag,
  input  logic              ovFlag,
  input  logic              ocFlag,
  input  logic              pgOutFlag,
  input  logic              hsShort,
  input  logic              otHot,
  output logic [CODE_W-1:0] ssCode,
  output logic              pwmEn,
  output logic              syncRectEn,
  output logic              powerGood,
  output logic              faultLatched,
  output logic              enDischarge
);
  localparam int SYNC_CODE = (REG_CODE * 95) / 100;

  dpCtrlT ctl;
  dpStatT stat;

  startFaultCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .cycleStb     (cycleStb),
    .uvloOk       (uvloOk),
    .enLevel      (enLevel),
    .fbShort      (fbShort),
    .hsShort      (hsShort),
    .otHot        (otHot),
    .stat         (stat),
    .ctl          (ctl),
    .pwmEn        (pwmEn),
    .syncRectEn   (syncRectEn),
    .powerGood    (powerGood),
    .faultLatched (faultLatched),
    .enDischarge  (enDischarge)
  );

  startFaultDatapath #(
    .CODE_W    (CODE_W),
    .END_CODE  (END_CODE),
    .SYNC_CODE (SYNC_CODE),
    .UV_LEN    (UV_LEN),
    .OV_LEN    (OV_LEN),
    .OC_LEN    (OC_LEN),
    .PG_LEN    (PG_LEN)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .cycleStb  (cycleStb),
    .uvFlag    (uvFlag),
    .ovFlag    (ovFlag),
    .ocFlag    (ocFlag),
    .pgOutFlag (pgOutFlag),
    .ctl       (ctl),
    .stat      (stat),
    .ssCode    (ssCode)
  );

endmodule

// File: tb/tb_startFaultSupervisor.sv
module tb_startFaultSupervisor;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 8;

  localparam int SEL_CODE = 0, SEL_PWM = 1, SEL_SYNC = 2, SEL_PG = 3,
                 SEL_FAULT = 4, SEL_DIS = 5;

  logic clk = 1'b0;
  logic rstN, cycleStb, uvloOk, enLevel, fbShort;
  logic uvFlag, ovFlag, ocFlag, pgOutFlag, hsShort, otHot;
  logic [CODE_W-1:0] ssCode;
  logic pwmEn, syncRectEn, powerGood, faultLatched, enDischarge;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  typedef struct {
    string tag;
    int    sel;
    int    expv;
  } expT;
  expT expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  startFaultSupervisor #(
    .CODE_W(CODE_W), .REG_CODE(32), .END_CODE(40),
    .UV_LEN(16), .OV_LEN(2), .OC_LEN(16), .PG_LEN(2)
  ) dut (
    .clk(clk), .rstN(rstN), .cycleStb(cycleStb), .uvloOk(uvloOk),
    .enLevel(enLevel), .fbShort(fbShort), .uvFlag(uvFlag), .ovFlag(ovFlag),
    .ocFlag(ocFlag), .pgOutFlag(pgOutFlag), .hsShort(hsShort), .otHot(otHot),
    .ssCode(ssCode), .pwmEn(pwmEn), .syncRectEn(syncRectEn),
    .powerGood(powerGood), .faultLatched(faultLatched),
    .enDischarge(enDischarge)
  );

  function automatic int readOut(int sel);
    case (sel)
      SEL_CODE:  return int'(ssCode);
      SEL_PWM:   return int'(pwmEn);
      SEL_SYNC:  return int'(syncRectEn);
      SEL_PG:    return int'(powerGood);
      SEL_FAULT: return int'(faultLatched);
      default:   return int'(enDischarge);
    endcase
  endfunction

  // monitor: compare queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        expT it;
        int act;
        it = expQ.pop_front();
        act = readOut(it.sel);
        checks++;
        if (act != it.expv) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.tag, it.sel, act, it.expv);
        end
      end
    end
  end

  task automatic pushExp(string tag, int sel, int expv);
    expT it;
    it.tag = tag; it.sel = sel; it.expv = expv;
    expQ.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic swCycle(logic uv, logic ov, logic oc, logic pgo);
    uvFlag = uv; ovFlag = ov; ocFlag = oc; pgOutFlag = pgo;
    cycleStb = 1'b1;
    @(negedge clk);
    cycleStb = 1'b0;
    uvFlag = 1'b0; ovFlag = 1'b0; ocFlag = 1'b0; pgOutFlag = 1'b0;
  endtask

  task automatic cleanCycles(int n);
    for (int i = 0; i < n; i++) swCycle(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic restart();
    enLevel = 1'b0;
    tick(1);
    pushExp("R12 fault cleared by enable low", SEL_FAULT, 0);
    enLevel = 1'b1;
    tick(1);
    pushExp("R12 fresh ramp starts", SEL_PWM, 1);
    pushExp("R12 fresh ramp from zero", SEL_CODE, 0);
  endtask

  // driver
  initial begin
    rstN = 1'b0; cycleStb = 1'b0; uvloOk = 1'b0; enLevel = 1'b0; fbShort = 1'b0;
    uvFlag = 1'b0; ovFlag = 1'b0; ocFlag = 1'b0; pgOutFlag = 1'b0;
    hsShort = 1'b0; otHot = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    pushExp("R1 reset code", SEL_CODE, 0);
    pushExp("R1 reset pwm", SEL_PWM, 0);
    pushExp("R1 reset sync", SEL_SYNC, 0);
    pushExp("R1 reset pg", SEL_PG, 0);
    pushExp("R1 reset fault", SEL_FAULT, 0);
    pushExp("R1 reset discharge", SEL_DIS, 0);

    // R2: enable without supply, then feedback short
    enLevel = 1'b1;
    tick(3);
    pushExp("R2 no start without uvloOk", SEL_PWM, 0);
    fbShort = 1'b1; uvloOk = 1'b1;
    tick(3);
    pushExp("R2 fb short holds idle", SEL_PWM, 0);
    fbShort = 1'b0;
    tick(1);
    pushExp("R2 start after short clears", SEL_PWM, 1);

    // R3/R4/R5 ramp with masked voltage flags
    for (int i = 0; i < 10; i++) swCycle(1'b1, 1'b1, 1'b0, 1'b1);
    pushExp("R3 code after 10 steps", SEL_CODE, 10);
    pushExp("R5 voltage flags masked in ramp", SEL_FAULT, 0);
    pushExp("R5 no pg in ramp", SEL_PG, 0);
    cleanCycles(19);
    pushExp("R4 sync off below threshold", SEL_SYNC, 0);
    cleanCycles(1);
    pushExp("R4 sync on at threshold", SEL_SYNC, 1);
    pushExp("R3 code 30", SEL_CODE, 30);
    cleanCycles(10);
    pushExp("R3 code at end", SEL_CODE, 40);
    pushExp("R11 pg low before run", SEL_PG, 0);
    cleanCycles(3);
    pushExp("R3 code holds at end", SEL_CODE, 40);
    pushExp("R11 pg high in run", SEL_PG, 1);
    pushExp("R4 sync on in run", SEL_SYNC, 1);

    // R11 power-good window filter
    swCycle(1'b0, 1'b0, 1'b0, 1'b1);
    pushExp("R11 pg held after one bad", SEL_PG, 1);
    swCycle(1'b0, 1'b0, 1'b0, 1'b1);
    pushExp("R11 pg low after two bad", SEL_PG, 0);
    swCycle(1'b0, 1'b0, 1'b0, 1'b0);
    pushExp("R11 pg back after good", SEL_PG, 1);

    // R7 over-voltage with a gap
    swCycle(1'b0, 1'b1, 1'b0, 1'b0);
    swCycle(1'b0, 1'b0, 1'b0, 1'b0);
    swCycle(1'b0, 1'b1, 1'b0, 1'b0);
    tick(1);
    pushExp("R7 gap restarts ov count", SEL_FAULT, 0);
    swCycle(1'b0, 1'b1, 1'b0, 1'b0);
    tick(1);
    pushExp("R7 ov trips after two", SEL_FAULT, 1);
    pushExp("R12 discharge in fault", SEL_DIS, 1);
    pushExp("R12 pwm off in fault", SEL_PWM, 0);
    pushExp("R12 sync off in fault", SEL_SYNC, 0);
    tick(1);
    pushExp("R12 code cleared in fault", SEL_CODE, 0);
    tick(5);
    pushExp("R12 fault held with enable high", SEL_FAULT, 1);
    restart();

    // R8 over-current live in ramp, gap restarts count
    for (int i = 0; i < 15; i++) swCycle(1'b0, 1'b0, 1'b1, 1'b0);
    tick(1);
    pushExp("R8 no oc trip at 15", SEL_FAULT, 0);
    swCycle(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 15; i++) swCycle(1'b0, 1'b0, 1'b1, 1'b0);
    tick(1);
    pushExp("R8 gap restarts oc count", SEL_FAULT, 0);
    swCycle(1'b0, 1'b0, 1'b1, 1'b0);
    tick(1);
    pushExp("R8 oc trips at 16 in ramp", SEL_FAULT, 1);
    restart();

    // R10 over-temperature
    cleanCycles(3);
    otHot = 1'b1;
    tick(1);
    pushExp("R10 ot trips", SEL_FAULT, 1);
    enLevel = 1'b0;
    tick(1);
    enLevel = 1'b1;
    tick(3);
    pushExp("R10 no start while hot", SEL_PWM, 0);
    otHot = 1'b0;
    tick(1);
    pushExp("R10 start after cooling", SEL_PWM, 1);

    // R9 shorted high side
    cleanCycles(2);
    hsShort = 1'b1;
    tick(1);
    pushExp("R9 hs short trips at once", SEL_FAULT, 1);
    hsShort = 1'b0;
    restart();

    // R6 under-voltage in run
    cleanCycles(40);
    tick(1);
    pushExp("R6 in run before uv", SEL_PG, 1);
    for (int i = 0; i < 15; i++) swCycle(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1);
    pushExp("R6 no uv trip at 15", SEL_FAULT, 0);
    swCycle(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1);
    pushExp("R6 uv trips at 16", SEL_FAULT, 1);
    restart();

    // R13 enable drop mid ramp
    cleanCycles(5);
    pushExp("R13 code before drop", SEL_CODE, 5);
    enLevel = 1'b0;
    tick(1);
    pushExp("R13 pwm off after enable low", SEL_PWM, 0);
    tick(1);
    pushExp("R13 code cleared", SEL_CODE, 0);

    // R13 supply loss clears fault
    enLevel = 1'b1;
    tick(1);
    hsShort = 1'b1;
    tick(1);
    pushExp("R13 fault before uvlo loss", SEL_FAULT, 1);
    hsShort = 1'b0;
    uvloOk = 1'b0;
    tick(1);
    pushExp("R13 uvlo loss clears fault", SEL_FAULT, 0);
    pushExp("R13 uvlo loss clears discharge", SEL_DIS, 0);
    uvloOk = 1'b1;
    tick(1);
    pushExp("R13 restart after supply back", SEL_PWM, 1);

    tick(3);
    done = 1'b1;
  end

  // watchdog and summary
  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule